// File: doc/BRIEF.md
# Vector Chaining Issue Controller

This controller sequences three vector functional units (a load unit, a multiplier and an adder) that pass whole vectors to one another through a bank of vector registers. It takes decoded vector instructions in program order from the head of an external instruction queue. It decides when each one may start, and then paces every unit element by element. A dependent instruction does not have to wait for its producer to finish. It may start as soon as the first element it needs has been written, and from then on it follows the producer one element at a time. In effect, the registers act as a forwarding path between the units.

For each vector register the controller keeps a count of the elements already written. A consumer may issue element i only when every source register it reads holds more than i written elements. A mode input turns chaining off. In that mode a consumer starts only once its sources are fully written, so the two schedules can be compared on the same program. Each unit has a fixed pipeline latency, and an element's result becomes readable that many cycles after the element is issued. The arithmetic datapaths and the memory timing lie outside this block. Its outputs are only the start, element-advance and writeback strobes.

Top module: `vchain_ctrl`

## Requirements
- R1: While reset is low, iq_take, unit_start, unit_adv and unit_wb are all 0. After reset every vector register counts as fully written (VLEN elements).
- R2: At most one unit starts per cycle. iq_take is 1 exactly when the head instruction starts, and that start appears on unit_start[iq_unit] (unit codes: 0 load, 1 multiply, 2 add).
- R3: A head instruction with no register overlap with any unfinished work starts in the same cycle it is presented, if its unit is idle.
- R4: A unit that has started an instruction is busy until it has issued all VLEN elements. It accepts its next instruction no earlier than the cycle after its last element.
- R5: An element issued (unit_adv) in cycle t produces a unit_wb pulse on the same unit in cycle t+LAT-1, and it counts as readable from cycle t+LAT, where LAT is that unit's latency.
- R6: With chain_en=1, a multiply or add issues element i (element 0 at its start) only in a cycle in which both source registers hold at least i+1 readable elements.
- R7: With chain_en=0, a multiply or add starts only once both source registers hold all VLEN elements.
- R8: A head instruction whose destination still has elements outstanding waits until that register is fully written.
- R9: A head instruction whose destination is a source of a multiply or add that is still issuing elements waits until that unit has issued its last element.
- R10: A load reads no vector register. Its iq_src_a and iq_src_b fields have no effect on when it starts.
- R11: Instructions start strictly in queue order. An instruction behind a stalled head does not start before the head does.
- R12: Every started instruction produces exactly VLEN unit_adv pulses and VLEN unit_wb pulses on its unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chain_en | input | 1 | 1: consumers follow producers element by element; 0: consumers wait for complete sources |
| iq_valid | input | 1 | The instruction queue head holds an instruction |
| iq_unit | input | 2 | Unit code of the head: 0 load, 1 multiply, 2 add |
| iq_dst | input | $clog2(NREG) | Destination vector register |
| iq_src_a | input | $clog2(NREG) | First source register (ignored for loads) |
| iq_src_b | input | $clog2(NREG) | Second source register (ignored for loads) |
| iq_take | output | 1 | The head starts this cycle and is removed from the queue |
| unit_start | output | 3 | Per-unit start strobe, indexed by unit code |
| unit_adv | output | 3 | Per-unit element-advance strobe (one element issued) |
| unit_wb | output | 3 | Per-unit element writeback strobe |

## Verification
iq_take and unit_start depend combinationally on the head presented in the same cycle. A unit_adv pulse for element i is due in the first cycle in which the source counts allow it. The matching unit_wb is due LAT-1 cycles after that unit_adv, and a dependent unit_adv is due no earlier than LAT cycles after it. The bench drives each head just after the falling edge and samples all outputs one nanosecond later. It compares them every cycle with a behavioural model that keeps pending writebacks as due-cycle queues. It also checks the start-to-start distances of each scenario against fixed numbers worked out from VLEN and the latencies, for example LAT_LD between a load and its chained multiply, and VLEN-1+LAT_LD without chaining.

// File: rtl/vchain_pkg.sv
// Package: shared unit codes and the element-readiness rule used by the
// issue logic and by every unit sequencer.
package vchain_pkg;

    localparam int NUNITS = 3;

    typedef enum logic [1:0] {
        U_LOAD = 2'd0,
        U_MUL  = 2'd1,
        U_ADD  = 2'd2
    } unit_e;

    // True when an element with index idx may be issued, given the readable
    // counts of both sources; units that read no register are always ready.
    function automatic logic elem_ready(input int avail_a, input int avail_b,
                                        input int idx, input logic chain,
                                        input int vlen, input logic reads);
        int need;
        need = chain ? idx + 1 : vlen;
        return !reads || ((avail_a >= need) && (avail_b >= need));
    endfunction

endpackage

// File: rtl/vc_reg_track.sv
// Per-register readable-element counters.
// Does: each register counts the elements written so far (VLEN = complete).
// A new allocation clears the count, and each writeback aimed at the
// register adds one.
// Assumes: at most one writer per register is outstanding, so no two units
// write back the same register in one cycle, and an allocation never meets
// a writeback to the same register.
module vc_reg_track #(
    parameter int NREG = 8,
    parameter int VLEN = 8,
    parameter int NU   = 3,
    parameter int RW   = $clog2(NREG),
    parameter int CW   = $clog2(VLEN + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_en,
    input  logic [RW-1:0]            alloc_reg,
    input  logic [NU-1:0]            wb_en,
    input  logic [NU-1:0][RW-1:0]    wb_reg,
    output logic [NREG-1:0][CW-1:0]  avail
);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [CW-1:0] cnt_q;
        logic          hit;
        logic          alloc_hit;

        // Detect a writeback from any unit aimed at this register.
        always_comb begin
            hit = 1'b0;
            for (int u = 0; u < NU; u++) begin
                if (wb_en[u] && (wb_reg[u] == RW'(r))) hit = 1'b1;
            end
        end

        assign alloc_hit = alloc_en && (alloc_reg == RW'(r));

        // Clear on allocation, count up on writeback, full after reset.
        always_ff @(posedge clk) begin
            if (!rst_n)         cnt_q <= CW'(VLEN);
            else if (alloc_hit) cnt_q <= '0;
            else if (hit)       cnt_q <= cnt_q + 1'b1;
        end

        assign avail[r] = cnt_q;

        // R5: a writeback never lands on an already complete register.
        a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            hit |-> (cnt_q != CW'(VLEN)));

        // R8: an allocated register is complete and receives no writeback.
        a_r8_alloc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_hit |-> (!hit && (cnt_q == CW'(VLEN))));
    end

endmodule

// File: rtl/vc_unit_seq.sv
// One functional unit's element sequencer and result-latency pipe.
// Does: on start it issues element 0 at once, then one element in each
// cycle in which its sources hold enough readable elements. Every issued
// element reappears as a writeback strobe LAT-1 cycles later and tagged
// with its destination, so the result is readable LAT cycles after issue.
// Assumes: start arrives only while the unit is idle, and LAT >= 1.
module vc_unit_seq
    import vchain_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int VLEN  = 8,
    parameter int LAT   = 3,
    parameter bit READS = 1'b1,
    parameter int RW    = $clog2(NREG),
    parameter int CW    = $clog2(VLEN + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     chain_en,
    input  logic                     start,
    input  logic [RW-1:0]            start_dst,
    input  logic [RW-1:0]            start_sa,
    input  logic [RW-1:0]            start_sb,
    input  logic [NREG-1:0][CW-1:0]  avail,
    output logic                     busy,
    output logic [RW-1:0]            cur_sa,
    output logic [RW-1:0]            cur_sb,
    output logic                     adv,
    output logic                     wb_en,
    output logic [RW-1:0]            wb_reg
);

    logic          active;
    logic [CW-1:0] idx;
    logic [RW-1:0] dst_q, sa_q, sb_q;
    logic          go;
    logic [RW-1:0] issue_dst;

    // Continue the running instruction when its next element is ready.
    assign go = active && elem_ready(int'(avail[sa_q]), int'(avail[sb_q]),
                                     int'(idx), chain_en, VLEN, READS);
    assign adv       = start || go;
    assign issue_dst = start ? start_dst : dst_q;

    // Instruction state: element index and the registers in use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            dst_q  <= '0;
            sa_q   <= '0;
            sb_q   <= '0;
        end else if (start) begin
            active <= (VLEN > 1);
            idx    <= CW'(1);
            dst_q  <= start_dst;
            sa_q   <= start_sa;
            sb_q   <= start_sb;
        end else if (go) begin
            idx <= idx + 1'b1;
            if (idx == CW'(VLEN - 1)) active <= 1'b0;
        end
    end

    assign busy   = active;
    assign cur_sa = sa_q;
    assign cur_sb = sb_q;

    if (LAT == 1) begin : g_lat_direct
        assign wb_en  = adv;
        assign wb_reg = issue_dst;
    end else begin : g_lat_pipe
        logic [LAT-2:0]         pv;
        logic [LAT-2:0][RW-1:0] pd;

        // Shift issued elements and their destination toward writeback.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pv <= '0;
                pd <= '0;
            end else begin
                pv[0] <= adv;
                pd[0] <= issue_dst;
                for (int k = 1; k < LAT - 1; k++) begin
                    pv[k] <= pv[k-1];
                    pd[k] <= pd[k-1];
                end
            end
        end

        assign wb_en  = pv[LAT-2];
        assign wb_reg = pd[LAT-2];
    end

    // R4: a new instruction is only handed to an idle unit.
    a_r4_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);

    // R12: a running instruction's element index stays within 1..VLEN-1.
    a_r12_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ((idx != '0) && (idx < CW'(VLEN))));

endmodule

// File: rtl/vc_issue.sv
// In-order issue decision for the head of the instruction queue.
// Does: starts the head when its unit is idle, its destination is complete
// (no outstanding write), its destination is not read by a unit still
// issuing, and element 0 of its sources is ready under the current mode.
// Assumes: unit codes above 2 never appear, and an instruction does not
// name its own destination as a source.
module vc_issue
    import vchain_pkg::*;
#(
    parameter int NREG = 8,
    parameter int VLEN = 8,
    parameter int NU   = 3,
    parameter int RW   = $clog2(NREG),
    parameter int CW   = $clog2(VLEN + 1)
) (
    input  logic                     en,
    input  logic                     chain_en,
    input  logic                     iq_valid,
    input  logic [1:0]               iq_unit,
    input  logic [RW-1:0]            iq_dst,
    input  logic [RW-1:0]            iq_sa,
    input  logic [RW-1:0]            iq_sb,
    input  logic [NU-1:0]            busy,
    input  logic [NU-1:0][RW-1:0]    act_sa,
    input  logic [NU-1:0][RW-1:0]    act_sb,
    input  logic [NREG-1:0][CW-1:0]  avail,
    output logic                     take,
    output logic [NU-1:0]            start
);

    logic unit_ok, unit_busy, war, dst_full, src_ok, reads;

    // Look up the target unit and scan running readers for a WAR clash.
    always_comb begin
        unit_ok   = 1'b0;
        unit_busy = 1'b0;
        war       = 1'b0;
        for (int u = 0; u < NU; u++) begin
            if (iq_unit == 2'(u)) begin
                unit_ok   = 1'b1;
                unit_busy = busy[u];
            end
            if ((u != int'(U_LOAD)) && busy[u] &&
                ((iq_dst == act_sa[u]) || (iq_dst == act_sb[u])))
                war = 1'b1;
        end
    end

    assign reads    = (iq_unit != U_LOAD);
    assign dst_full = (avail[iq_dst] == CW'(VLEN));
    assign src_ok   = elem_ready(int'(avail[iq_sa]), int'(avail[iq_sb]), 0,
                                 chain_en, VLEN, reads);

    assign take = en && iq_valid && unit_ok && !unit_busy && dst_full &&
                  !war && src_ok;

    // Route the start to the unit the head names.
    always_comb begin
        for (int u = 0; u < NU; u++) start[u] = take && (iq_unit == 2'(u));
    end

endmodule

// File: rtl/vchain_ctrl.sv
// Top: vector chaining issue controller for a load, a multiply and an add
// unit sharing NREG vector registers of VLEN elements.
// Does: connects the in-order issue stage, one sequencer per unit (each
// with its own latency) and the per-register readable-element counters.
// Assumes: the instruction queue holds its head steady until iq_take.
module vchain_ctrl
    import vchain_pkg::*;
#(
    parameter int NREG    = 8,
    parameter int VLEN    = 8,
    parameter int LAT_LD  = 3,
    parameter int LAT_MUL = 4,
    parameter int LAT_ADD = 2,
    localparam int RW     = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chain_en,
    input  logic          iq_valid,
    input  logic [1:0]    iq_unit,
    input  logic [RW-1:0] iq_dst,
    input  logic [RW-1:0] iq_src_a,
    input  logic [RW-1:0] iq_src_b,
    output logic          iq_take,
    output logic [2:0]    unit_start,
    output logic [2:0]    unit_adv,
    output logic [2:0]    unit_wb
);

    localparam int NU = NUNITS;
    localparam int CW = $clog2(VLEN + 1);

    logic [NU-1:0]           busy;
    logic [NU-1:0][RW-1:0]   act_sa, act_sb, wb_reg;
    logic [NU-1:0]           wb_en, adv, start;
    logic [NREG-1:0][CW-1:0] avail;

    vc_issue #(.NREG(NREG), .VLEN(VLEN), .NU(NU), .RW(RW), .CW(CW)) u_issue (
        .en       (rst_n),
        .chain_en (chain_en),
        .iq_valid (iq_valid),
        .iq_unit  (iq_unit),
        .iq_dst   (iq_dst),
        .iq_sa    (iq_src_a),
        .iq_sb    (iq_src_b),
        .busy     (busy),
        .act_sa   (act_sa),
        .act_sb   (act_sb),
        .avail    (avail),
        .take     (iq_take),
        .start    (start)
    );

    for (genvar g = 0; g < NU; g++) begin : g_unit
        localparam int LAT_G = (g == 0) ? LAT_LD : (g == 1) ? LAT_MUL : LAT_ADD;

        vc_unit_seq #(.NREG(NREG), .VLEN(VLEN), .LAT(LAT_G),
                      .READS(g != 0), .RW(RW), .CW(CW)) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .chain_en  (chain_en),
            .start     (start[g]),
            .start_dst (iq_dst),
            .start_sa  (iq_src_a),
            .start_sb  (iq_src_b),
            .avail     (avail),
            .busy      (busy[g]),
            .cur_sa    (act_sa[g]),
            .cur_sb    (act_sb[g]),
            .adv       (adv[g]),
            .wb_en     (wb_en[g]),
            .wb_reg    (wb_reg[g])
        );
    end

    vc_reg_track #(.NREG(NREG), .VLEN(VLEN), .NU(NU), .RW(RW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (iq_take),
        .alloc_reg (iq_dst),
        .wb_en     (wb_en),
        .wb_reg    (wb_reg),
        .avail     (avail)
    );

    assign unit_start = start;
    assign unit_adv   = adv;
    assign unit_wb    = wb_en;

    // R2: no two units start in the same cycle.
    a_r2_one_start: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unit_start));

endmodule

// File: tb/vchain_ctrl_tb.sv
`timescale 1ns/1ps
module vchain_ctrl_tb;

    localparam int NREG = 8, VLEN = 8;
    localparam int LAT_LD = 3, LAT_MUL = 4, LAT_ADD = 2;
    int lat[3] = '{LAT_LD, LAT_MUL, LAT_ADD};

    logic clk = 1'b0, rst_n = 1'b0, chain_en = 1'b1;
    logic iq_valid;
    logic [1:0] iq_unit;
    logic [2:0] iq_dst, iq_src_a, iq_src_b;
    logic iq_take;
    logic [2:0] unit_start, unit_adv, unit_wb;

    vchain_ctrl #(.NREG(NREG), .VLEN(VLEN), .LAT_LD(LAT_LD),
                  .LAT_MUL(LAT_MUL), .LAT_ADD(LAT_ADD)) u_dut (
        .clk(clk), .rst_n(rst_n), .chain_en(chain_en), .iq_valid(iq_valid),
        .iq_unit(iq_unit), .iq_dst(iq_dst), .iq_src_a(iq_src_a),
        .iq_src_b(iq_src_b), .iq_take(iq_take), .unit_start(unit_start),
        .unit_adv(unit_adv), .unit_wb(unit_wb));

    always #2.5 clk = ~clk;

    typedef struct { int unit; int dst; int sa; int sb; } ins_t;
    ins_t iq[$];

    int checks = 0, fails = 0, cyc = 0;
    // behavioural model state
    int mcnt[NREG];
    bit mact[3];
    int midx[3], mdst[3], msa[3], msb[3];
    int wdue[3][$];
    int wdst[3][$];
    // observation logs
    int slog_c[$];
    int fwb[3];
    int n_st[3], n_adv[3], n_wb[3];

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic bit m_ready(int u, int a, int b, int idx);
        int need;
        if (u == 0) return 1'b1;
        need = chain_en ? idx + 1 : VLEN;
        return (mcnt[a] >= need) && (mcnt[b] >= need);
    endfunction

    task automatic drive_head();
        if (iq.size() > 0) begin
            iq_valid = 1'b1; iq_unit = 2'(iq[0].unit); iq_dst = 3'(iq[0].dst);
            iq_src_a = 3'(iq[0].sa); iq_src_b = 3'(iq[0].sb);
        end else begin
            iq_valid = 1'b0; iq_unit = '0; iq_dst = '0; iq_src_a = '0; iq_src_b = '0;
        end
    endtask

    // One cycle of the model: expected outputs, comparison, state update.
    task automatic step();
        bit take, war;
        bit st[3], cont[3], wbx[3];
        ins_t h;
        take = 1'b0; war = 1'b0;
        if (iq.size() > 0) begin
            h = iq[0];
            for (int u = 1; u < 3; u++)
                if (mact[u] && (h.dst == msa[u] || h.dst == msb[u])) war = 1'b1;
            take = !mact[h.unit] && (mcnt[h.dst] == VLEN) && !war &&
                   m_ready(h.unit, h.sa, h.sb, 0);
        end
        for (int u = 0; u < 3; u++) begin
            st[u]   = take && (h.unit == u);
            cont[u] = mact[u] && m_ready(u, msa[u], msb[u], midx[u]);
            if (st[u] || cont[u]) begin
                wdue[u].push_back(cyc + lat[u] - 1);
                wdst[u].push_back(st[u] ? h.dst : mdst[u]);
            end
            wbx[u] = (wdue[u].size() > 0) && (wdue[u][0] == cyc);
        end
        check(iq_take == take, "R2", "iq_take", int'(iq_take), int'(take));
        for (int u = 0; u < 3; u++) begin
            check(unit_start[u] == st[u], "R3", $sformatf("unit_start[%0d]", u),
                  int'(unit_start[u]), int'(st[u]));
            check(unit_adv[u] == (st[u] || cont[u]), "R6", $sformatf("unit_adv[%0d]", u),
                  int'(unit_adv[u]), int'(st[u] || cont[u]));
            check(unit_wb[u] == wbx[u], "R5", $sformatf("unit_wb[%0d]", u),
                  int'(unit_wb[u]), int'(wbx[u]));
            if (unit_start[u]) begin n_st[u]++; slog_c.push_back(cyc); end
            if (unit_adv[u]) n_adv[u]++;
            if (unit_wb[u]) begin n_wb[u]++; if (fwb[u] < 0) fwb[u] = cyc; end
        end
        // state update as at the next rising edge
        for (int u = 0; u < 3; u++) begin
            if (wbx[u]) begin
                mcnt[wdst[u][0]]++;
                void'(wdue[u].pop_front());
                void'(wdst[u].pop_front());
            end
            if (cont[u]) begin
                midx[u]++;
                if (midx[u] == VLEN) mact[u] = 1'b0;
            end
        end
        if (take) begin
            mcnt[h.dst] = 0;
            mact[h.unit] = (VLEN > 1); midx[h.unit] = 1;
            mdst[h.unit] = h.dst; msa[h.unit] = h.sa; msb[h.unit] = h.sb;
            void'(iq.pop_front());
        end
        cyc++;
    endtask

    function automatic bit idle();
        bit b;
        b = (iq.size() == 0);
        for (int u = 0; u < 3; u++) b = b && !mact[u] && (wdue[u].size() == 0);
        return b;
    endfunction

    task automatic run_idle();
        int n;
        n = 0;
        forever begin
            @(negedge clk); drive_head(); #1; step(); n++;
            if (idle()) break;
            if (n > 400) begin
                check(1'b0, "R2", "scenario watchdog", n, 400);
                iq.delete();
                break;
            end
        end
    endtask

    task automatic scen(bit ch);
        @(negedge clk);
        chain_en = ch;
        slog_c.delete();
        for (int u = 0; u < 3; u++) fwb[u] = -1;
    endtask

    task automatic push(int u, int d, int a, int b);
        ins_t t;
        t.unit = u; t.dst = d; t.sa = a; t.sb = b;
        iq.push_back(t);
    endtask

    task automatic gap(int i, int j, int exp, string req);
        int act;
        act = (slog_c.size() > j) ? slog_c[j] - slog_c[i] : -1;
        check(act == exp, req, $sformatf("start distance %0d->%0d", i, j), act, exp);
    endtask

    initial begin
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL R2 global watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int r = 0; r < NREG; r++) mcnt[r] = VLEN;
        for (int u = 0; u < 3; u++) begin
            mact[u] = 0; midx[u] = 0; n_st[u] = 0; n_adv[u] = 0; n_wb[u] = 0; fwb[u] = -1;
        end
        // R1: outputs stay quiet during reset, even with a ready head
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            iq_valid = 1'b1; iq_unit = 2'd0; iq_dst = 3'd1; iq_src_a = '0; iq_src_b = '0;
            #1;
            check(iq_take == 1'b0, "R1", "iq_take in reset", int'(iq_take), 0);
            check(unit_start == 3'b0, "R1", "unit_start in reset", int'(unit_start), 0);
            check(unit_adv == 3'b0, "R1", "unit_adv in reset", int'(unit_adv), 0);
            check(unit_wb == 3'b0, "R1", "unit_wb in reset", int'(unit_wb), 0);
        end
        @(negedge clk); rst_n = 1'b1; drive_head();

        // R6 / R1: three-stage chain load v1; v3=v1*v2; v5=v3+v4
        scen(1'b1);
        push(0, 1, 0, 0); push(1, 3, 1, 2); push(2, 5, 3, 4);
        run_idle();
        gap(0, 1, LAT_LD, "R6");
        gap(1, 2, LAT_MUL, "R6");
        check((slog_c.size() > 0) && (fwb[0] - slog_c[0] == LAT_LD - 1), "R5",
              "first load writeback offset", fwb[0] - slog_c[0], LAT_LD - 1);

        // R7: same chain, chaining disabled
        scen(1'b0);
        push(0, 1, 0, 0); push(1, 3, 1, 2); push(2, 5, 3, 4);
        run_idle();
        gap(0, 1, VLEN - 1 + LAT_LD, "R7");
        gap(1, 2, VLEN - 1 + LAT_MUL, "R7");

        // R3: independent instructions start back to back
        scen(1'b1);
        push(0, 6, 0, 0); push(1, 7, 2, 4); push(2, 0, 2, 4);
        run_idle();
        gap(0, 1, 1, "R3");
        gap(1, 2, 1, "R3");

        // R4: second load waits for the first to issue all elements
        scen(1'b1);
        push(0, 1, 0, 0); push(0, 2, 0, 0);
        run_idle();
        gap(0, 1, VLEN, "R4");

        // R8: multiply into v6 waits for the load of v6 to complete
        scen(1'b1);
        push(0, 6, 0, 0); push(1, 6, 2, 4);
        run_idle();
        gap(0, 1, VLEN - 1 + LAT_LD, "R8");

        // R9: load into v1 waits while the multiply still reads v1
        scen(1'b1);
        push(1, 3, 1, 2); push(0, 1, 0, 0);
        run_idle();
        gap(0, 1, VLEN, "R9");

        // R10: load naming a pending register as source starts at once
        scen(1'b1);
        push(1, 6, 2, 4); push(0, 5, 6, 6);
        run_idle();
        gap(0, 1, 1, "R10");

        // R11: independent add behind a stalled multiply keeps order
        scen(1'b0);
        push(0, 1, 0, 0); push(1, 3, 1, 2); push(2, 7, 2, 4);
        run_idle();
        gap(0, 1, VLEN - 1 + LAT_LD, "R11");
        gap(1, 2, 1, "R11");

        // R12: exactly VLEN element and writeback strobes per instruction
        for (int u = 0; u < 3; u++) begin
            check(n_adv[u] == VLEN * n_st[u], "R12", $sformatf("adv count unit %0d", u),
                  n_adv[u], VLEN * n_st[u]);
            check(n_wb[u] == VLEN * n_st[u], "R12", $sformatf("wb count unit %0d", u),
                  n_wb[u], VLEN * n_st[u]);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule